// File: doc/BRIEF.md
# AXI Burst to Memory Transaction Splitter

This block sits between the address channel of an AXI4 slave and the command side of a double-data-rate memory controller built around 16-bit words. It takes one read or write address request at a time (byte address, beat count minus one, and burst type). It turns the request into one or more transaction descriptors. Each descriptor gives the word address where the transaction starts, how many 16-bit words it moves, whether the memory must wrap inside its burst window, and whether the transaction reads or writes.

Linear requests are cut into chunks of at most `MAX_WORDS` words. The memory's chip select therefore never stays asserted longer than the device allows. Each chunk starts at the word that follows the previous one. Wrapping requests of 2, 4, 8 or 16 beats go out as one wrapped transaction. A wrapping request of any other length is refused with an error pulse. The final descriptor of every request carries a last flag, and a done pulse follows its acceptance. The response logic uses these two signals to complete the AXI transaction.

Top module: `mem_burst_splitter`

## Requirements
- R1: The first descriptor's word address equals the request byte address shifted right by one. The word counts of all descriptors of a request sum to (len+1)*DATA_W/16. No descriptor has a word count of zero.
- R2: A linear descriptor never carries more than MAX_WORDS words. Every linear descriptor except the last carries exactly MAX_WORDS words.
- R3: Each linear descriptor after the first starts at the previous descriptor's word address plus its word count.
- R4: Burst codes 0 (FIXED), 1 (INCR) and 3 (reserved) are all issued as linear transactions with descWrap at 0, so the address advances as it does for INCR.
- R5: Burst code 2 (WRAP) with len 1, 3, 7 or 15 yields exactly one descriptor, with descWrap at 1 and descLast at 1, carrying all (len+1)*DATA_W/16 words even when that count exceeds MAX_WORDS.
- R6: Burst code 2 with any other len raises reqError for exactly one cycle, the cycle after acceptance. No descriptor is issued and reqReady stays high.
- R7: descLast is 1 on the final descriptor of a request and 0 on every earlier one.
- R8: reqReady is high only when no descriptor is pending. It drops from the cycle after acceptance until the cycle after the last descriptor is accepted.
- R9: While descValid is high and descReady is low, descValid and all descriptor fields hold their values.
- R10: reqDone pulses high for exactly one cycle, the cycle after the last descriptor of a request is accepted.
- R11: After reset, reqReady is 1 and descValid, reqError and reqDone are 0.
- R12: descWrite equals reqWrite as sampled when the request was accepted, on every descriptor of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Address request present |
| reqReady | output | 1 | Splitter idle and able to take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | AXI byte address |
| reqLen | input | 8 | AXI beat count minus one |
| reqBurst | input | 2 | AXI burst type: 0 FIXED, 1 INCR, 2 WRAP |
| descValid | output | 1 | Descriptor present |
| descReady | input | 1 | Controller takes the descriptor |
| descAddr | output | ADDR_W-1 | Start address in 16-bit words |
| descWords | output | CNT_W | Word count of this transaction |
| descWrap | output | 1 | Wrapped burst |
| descWrite | output | 1 | Write transaction |
| descLast | output | 1 | Final descriptor of the request |
| reqError | output | 1 | One-cycle pulse for an unsupported wrap length |
| reqDone | output | 1 | One-cycle pulse after the final descriptor is accepted |

## Verification
The bench builds the block with DATA_W at 32 (two words per beat), ADDR_W at 32 and MAX_WORDS at 16.

With these values, an eight-beat linear request fills exactly one chunk and a nine-beat request spills into a second. A 256-beat write is cut into 32 chunks. A sixteen-beat wrap needs 32 words, which is twice the chunk limit, so the bench can confirm that wrapped bursts are never split. The odd byte address and the FIXED and reserved burst codes show that the address conversion and the burst-type mapping hold away from the plain INCR case.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burstKind_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // capture a fresh request
    logic advance;  // current chunk accepted, step to next
  } ctrlStrobe_t;

  // wrap lengths the memory supports: 2, 4, 8, 16 beats
  function automatic logic wrapLenLegal(input logic [7:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction

endpackage

// File: rtl/splitter_datapath.sv
module splitter_datapath
  import splitter_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MAX_WORDS = 16,
  parameter int CNT_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqLen,
  input  logic [1:0]        reqBurst,
  output logic [ADDR_W-2:0] descAddr,
  output logic [CNT_W-1:0]  descWords,
  output logic              descWrap,
  output logic              descWrite,
  output logic              chunkLast
);

  localparam int WORDS_PER_BEAT = DATA_W / 16;
  localparam int WADDR_W        = ADDR_W - 1;
  localparam logic [CNT_W-1:0] CHUNK_MAX = CNT_W'(MAX_WORDS);

  logic [WADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]   remainQ;
  logic               wrapQ;
  logic               writeQ;
  logic [CNT_W-1:0]   chunkWords;
  logic [CNT_W-1:0]   loadWords;
  logic               unusedByteLsb;

  assign unusedByteLsb = reqAddr[0];
  assign loadWords = (CNT_W'(reqLen) + CNT_W'(1)) * CNT_W'(WORDS_PER_BEAT);

  always_comb begin
    if (wrapQ) begin
      chunkWords = remainQ;
      chunkLast  = 1'b1;
    end else if (remainQ > CHUNK_MAX) begin
      chunkWords = CHUNK_MAX;
      chunkLast  = 1'b0;
    end else begin
      chunkWords = remainQ;
      chunkLast  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ   <= '0;
      remainQ <= '0;
      wrapQ   <= 1'b0;
      writeQ  <= 1'b0;
    end else if (strobe.load) begin
      addrQ   <= reqAddr[ADDR_W-1:1];
      remainQ <= loadWords;
      wrapQ   <= (reqBurst == BURST_WRAP);
      writeQ  <= reqWrite;
    end else if (strobe.advance) begin
      addrQ   <= addrQ + WADDR_W'(chunkWords);
      remainQ <= remainQ - chunkWords;
    end
  end

  assign descAddr  = addrQ;
  assign descWords = chunkWords;
  assign descWrap  = wrapQ;
  assign descWrite = writeQ;

  // an advance only ever happens while more than one chunk is still owed
  assert_advance_leaves_work_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> (remainQ != '0));

  // load and advance never coincide
  assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.load && strobe.advance));

endmodule

// File: rtl/splitter_control.sv
module splitter_control
  import splitter_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [7:0]  reqLen,
  input  logic [1:0]  reqBurst,
  input  logic        descReady,
  input  logic        chunkLast,
  output logic        reqReady,
  output logic        descValid,
  output logic        reqError,
  output logic        reqDone,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_ISSUE} ctrlState_e;

  ctrlState_e state;
  logic       badWrap;

  assign badWrap   = (reqBurst == BURST_WRAP) && !wrapLenLegal(reqLen);
  assign reqReady  = (state == ST_IDLE);
  assign descValid = (state == ST_ISSUE);

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == ST_IDLE) && reqValid && !badWrap;
    strobe.advance = (state == ST_ISSUE) && descReady && !chunkLast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      reqError <= 1'b0;
      reqDone  <= 1'b0;
    end else begin
      reqError <= 1'b0;
      reqDone  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (badWrap) reqError <= 1'b1;
            else         state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (descReady && chunkLast) begin
            state   <= ST_IDLE;
            reqDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // final handshake frees the request port and pulses done
  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (descValid && descReady && chunkLast) |=> (reqDone && reqReady));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reqDone |=> !reqDone);

  // a refused request never opens a descriptor
  assert_error_no_desc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reqError |-> (!descValid && !$past(reqError)));

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && !badWrap) |=> (descValid && !reqReady));

endmodule

// File: rtl/mem_burst_splitter.sv
module mem_burst_splitter
  import splitter_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MAX_WORDS = 16,
  localparam int CNT_W    = $clog2(256 * (DATA_W / 16) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqLen,
  input  logic [1:0]        reqBurst,
  output logic              descValid,
  input  logic              descReady,
  output logic [ADDR_W-2:0] descAddr,
  output logic [CNT_W-1:0]  descWords,
  output logic              descWrap,
  output logic              descWrite,
  output logic              descLast,
  output logic              reqError,
  output logic              reqDone
);

  ctrlStrobe_t strobe;
  logic        chunkLast;

  initial begin
    assert_width_legal: assert (DATA_W == 16 || DATA_W == 32 || DATA_W == 64);
    assert_limit_legal: assert (MAX_WORDS >= 1);
  end

  splitter_control u_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqLen    (reqLen),
    .reqBurst  (reqBurst),
    .descReady (descReady),
    .chunkLast (chunkLast),
    .reqReady  (reqReady),
    .descValid (descValid),
    .reqError  (reqError),
    .reqDone   (reqDone),
    .strobe    (strobe)
  );

  splitter_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MAX_WORDS (MAX_WORDS),
    .CNT_W     (CNT_W)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .reqBurst  (reqBurst),
    .descAddr  (descAddr),
    .descWords (descWords),
    .descWrap  (descWrap),
    .descWrite (descWrite),
    .chunkLast (chunkLast)
  );

  assign descLast = chunkLast;

  assert_chunk_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (descValid && !descWrap) |-> (descWords <= CNT_W'(MAX_WORDS)));

  assert_nonzero_words_R1: assert property (@(posedge clk) disable iff (!rst_n)
    descValid |-> (descWords != '0));

  assert_wrap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (descValid && descWrap) |-> descLast);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (descValid && !descReady) |=>
      (descValid && $stable(descAddr) && $stable(descWords) && $stable(descWrap)
       && $stable(descWrite) && $stable(descLast)));

  assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (descValid && descReady && !descLast) |=>
      (descValid && descAddr == $past(descAddr) + (ADDR_W-1)'($past(descWords))));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    descValid |-> !reqReady);

endmodule

// File: tb/mem_burst_splitter_tb.sv
module mem_burst_splitter_tb;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 32;
  localparam int MAX_WORDS = 16;
  localparam int CNT_W     = $clog2(256 * (DATA_W / 16) + 1);
  localparam int NVEC      = 10;

  // stimulus and expected outcome per request
  localparam logic [31:0] V_ADDR  [NVEC] = '{32'h100, 32'h1000, 32'h0300, 32'h0, 32'h2002,
                                             32'h40, 32'h88, 32'h500, 32'h7000, 32'h20};
  localparam logic [7:0]  V_LEN   [NVEC] = '{8'd0, 8'd7, 8'd8, 8'd255, 8'd20,
                                             8'd15, 8'd1, 8'd2, 8'd3, 8'd0};
  localparam logic [1:0]  V_BURST [NVEC] = '{2'd1, 2'd1, 2'd1, 2'd1, 2'd0,
                                             2'd2, 2'd2, 2'd2, 2'd3, 2'd2};
  localparam logic        V_WRITE [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                             1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int          V_TOTAL [NVEC] = '{2, 16, 18, 512, 42, 32, 4, 0, 8, 0};
  localparam logic        V_ERR   [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                             1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0]        reqLen = '0;
  logic [1:0]        reqBurst = '0;
  logic              descValid;
  logic              descReady = 1'b0;
  logic [ADDR_W-2:0] descAddr;
  logic [CNT_W-1:0]  descWords;
  logic              descWrap;
  logic              descWrite;
  logic              descLast;
  logic              reqError;
  logic              reqDone;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  mem_burst_splitter #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MAX_WORDS (MAX_WORDS)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .reqBurst  (reqBurst),
    .descValid (descValid),
    .descReady (descReady),
    .descAddr  (descAddr),
    .descWords (descWords),
    .descWrap  (descWrap),
    .descWrite (descWrite),
    .descLast  (descLast),
    .reqError  (reqError),
    .reqDone   (reqDone)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reqReady after reset", 64'(reqReady), 64'd1);
    chk("R11 descValid after reset", 64'(descValid), 64'd0);
    chk("R11 reqError after reset", 64'(reqError), 64'd0);
    chk("R11 reqDone after reset", 64'(reqDone), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      reqValid = 1'b1;
      reqWrite = V_WRITE[i];
      reqAddr  = V_ADDR[i];
      reqLen   = V_LEN[i];
      reqBurst = V_BURST[i];
      @(negedge clk);
      reqValid = 1'b0;
      reqLen   = 8'hAA;
      reqAddr  = '1;
      reqWrite = ~V_WRITE[i];
      if (V_ERR[i]) begin
        chk("R6 reqError pulse", 64'(reqError), 64'd1);
        chk("R6 no descriptor", 64'(descValid), 64'd0);
        chk("R6 reqReady stays high", 64'(reqReady), 64'd1);
        @(negedge clk);
        chk("R6 reqError one cycle", 64'(reqError), 64'd0);
        chk("R6 still no descriptor", 64'(descValid), 64'd0);
      end else begin
        logic        isWrap;
        logic [63:0] expAddr;
        int          rem;
        int          chunk;
        isWrap  = (V_BURST[i] == 2'd2);
        expAddr = 64'(V_ADDR[i] >> 1);
        rem     = V_TOTAL[i];
        chunk   = 0;
        while (rem > 0) begin
          int  expWords;
          logic expLast;
          expWords = (isWrap || rem <= MAX_WORDS) ? rem : MAX_WORDS;
          expLast  = (expWords == rem);
          chk("R8 descValid while busy", 64'(descValid), 64'd1);
          chk("R8 reqReady low while busy", 64'(reqReady), 64'd0);
          chk("R1 R3 descAddr", 64'(descAddr), expAddr);
          chk("R2 R5 descWords", 64'(descWords), 64'(expWords));
          chk("R4 R5 descWrap", 64'(descWrap), 64'(isWrap));
          chk("R7 descLast", 64'(descLast), 64'(expLast));
          chk("R12 descWrite", 64'(descWrite), 64'(V_WRITE[i]));
          if (chunk == 0 && (i % 2 == 0)) begin
            @(negedge clk);
            @(negedge clk);
            chk("R9 held descValid", 64'(descValid), 64'd1);
            chk("R9 held descAddr", 64'(descAddr), expAddr);
            chk("R9 held descWords", 64'(descWords), 64'(expWords));
            chk("R9 held descLast", 64'(descLast), 64'(expLast));
          end
          descReady = 1'b1;
          @(negedge clk);
          descReady = 1'b0;
          rem     = rem - expWords;
          expAddr = (expAddr + 64'(expWords)) & 64'h7FFF_FFFF;
          chunk++;
        end
        chk("R10 reqDone after last", 64'(reqDone), 64'd1);
        chk("R8 reqReady after last", 64'(reqReady), 64'd1);
        chk("R7 no descriptor after last", 64'(descValid), 64'd0);
        @(negedge clk);
        chk("R10 reqDone one cycle", 64'(reqDone), 64'd0);
        if (isWrap) chk("R5 wrap single descriptor", 64'(chunk), 64'd1);
        else        chk("R2 chunk count", 64'(chunk),
                        64'((V_TOTAL[i] + MAX_WORDS - 1) / MAX_WORDS));
      end
    end

    // directed: reset in the middle of a split request
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 32'h400; reqLen = 8'd63; reqBurst = 2'd1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8 busy before mid reset", 64'(reqReady), 64'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reqReady after mid reset", 64'(reqReady), 64'd1);
    chk("R11 descValid after mid reset", 64'(descValid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finishRun();
  end

endmodule